// File: doc/BRIEF.md
# Handshake-Triggered Variable Period Timer

This block is one timer channel that paces a request/acknowledge exchange with a partner. It raises its request output and holds it while it waits for the partner's acknowledge. The acknowledge starts timing. The request stays high for a programmed number of clock edges and then drops. A second programmed value sets how many edges after the acknowledge the period ends. At that point the channel signals a timeout, raises the request again and waits for the next acknowledge.

The time between timeouts is therefore not fixed. It is the period value plus however long the partner takes to answer. When the partner answers on the timeout edge itself, the next period follows with no gap. Software-facing registers sit outside the block: it sees the two reference values as plain inputs, and captures them only when a period starts.

Top module: `hs_var_timer`

## Requirements
- R1: Out of reset, and at any time while the channel waits for acknowledge, `init_req` is 1, `timeout` is 0 and the internal count rests at 1.
- R2: While `ack` stays 0 in the waiting state, the channel remains waiting for any number of cycles and produces no `timeout`.
- R3: With 1 <= `high_ref` < `period_ref`, `init_req` falls `high_ref` rising edges after the edge that sampled `ack`=1. It then stays 0 for `period_ref - high_ref` cycles.
- R4: `timeout` goes to 1 exactly `period_ref` rising edges after the edge that sampled `ack`=1. The count steps up by one on every edge of the counting phase until then.
- R5: `timeout` is a pulse one cycle wide per period end. `init_req` returns to 1 on that same edge, so it is 1 whenever `timeout` is 1.
- R6: If `ack` is 1 on the edge that ends a period, the next period starts on that edge, and consecutive `timeout` pulses are exactly `period_ref` cycles apart.
- R7: If `high_ref` >= `period_ref`, or `high_ref` = 0, `init_req` stays 1 for the whole period while timeouts still occur.
- R8: `ack` is ignored during the counting phase. A pulse there neither restarts nor shortens the period.
- R9: `en` = 0 returns the channel to the waiting state on the next edge, with count 1, `init_req` = 1 and `timeout` = 0.
- R10: `high_ref` and `period_ref` are captured on the edge that starts a period. Changes made during a period take effect only in the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Channel enable; 0 holds the channel idle |
| high_ref | input | CNT_W | Count at which the request drops |
| period_ref | input | CNT_W | Count at which the period ends (must be at least 1) |
| ack | input | 1 | Acknowledge from the partner |
| init_req | output | 1 | Request to the partner |
| timeout | output | 1 | One-cycle pulse at each period end |

## Verification
The bench builds the channel with the default 8-bit count. Reference values are kept at 10 or below so that each period lasts only a few cycles. That makes it cheap to run the R3/R4 timing checks, back-to-back periods and several waiting gaps in one short run. Edge cases covered include `high_ref` equal to, above and at zero relative to `period_ref`, and mid-period reference rewrites. A behavioural model runs beside the design and is compared against it on every cycle.

// File: rtl/hvt_pkg.sv
package hvt_pkg;
   typedef enum logic {
      PH_WAIT = 1'b0,
      PH_RUN  = 1'b1
   } phase_e;
endpackage

// File: rtl/hvt_ref_hold.sv
module hvt_ref_hold #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         capture,
   input  logic [W-1:0] hi_in,
   input  logic [W-1:0] per_in,
   output logic [W-1:0] hi_q,
   output logic [W-1:0] per_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= '0;
         per_q <= W'(1);
      end else if (capture) begin
         hi_q  <= hi_in;
         per_q <= per_in;
      end
   end
endmodule

// File: rtl/hvt_count.sv
module hvt_count #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         reload,
   input  logic         step,
   input  logic [W-1:0] hi_q,
   input  logic [W-1:0] per_q,
   output logic [W-1:0] cnt,
   output logic         at_hi,
   output logic         at_per
);
   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= ONE;
      else if (reload) cnt <= ONE;
      else if (step)   cnt <= cnt + ONE;
   end

   assign at_hi  = (cnt == hi_q);
   assign at_per = (cnt == per_q);
endmodule

// File: rtl/hs_var_timer.sv
module hs_var_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] high_ref,
   input  logic [CNT_W-1:0] period_ref,
   input  logic             ack,
   output logic             init_req,
   output logic             timeout
);
   import hvt_pkg::*;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("hs_var_timer: CNT_W must be between 2 and 32");
   end

   phase_e           phase_q;
   logic [CNT_W-1:0] hi_q, per_q, cnt_q;
   logic             at_hi, at_per;
   logic             running, period_end, start, cnt_reload, cnt_step;

   assign running    = (phase_q == PH_RUN);
   assign period_end = running && at_per;
   assign start      = en && ack && (!running || at_per);
   assign cnt_reload = !en || period_end;
   assign cnt_step   = en && running && !at_per;

   hvt_ref_hold #(.W(CNT_W)) u_refs (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (start),
      .hi_in   (high_ref),
      .per_in  (period_ref),
      .hi_q    (hi_q),
      .per_q   (per_q)
   );

   hvt_count #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .reload (cnt_reload),
      .step   (cnt_step),
      .hi_q   (hi_q),
      .per_q  (per_q),
      .cnt    (cnt_q),
      .at_hi  (at_hi),
      .at_per (at_per)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_WAIT;
         init_req <= 1'b1;
         timeout  <= 1'b0;
      end else if (!en) begin
         phase_q  <= PH_WAIT;
         init_req <= 1'b1;
         timeout  <= 1'b0;
      end else begin
         timeout <= 1'b0;
         if (!running) begin
            if (ack) phase_q <= PH_RUN;
         end else if (at_per) begin
            timeout  <= 1'b1;
            init_req <= 1'b1;
            phase_q  <= ack ? PH_RUN : PH_WAIT;
         end else if (at_hi) begin
            init_req <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/hvt_chk.sv
module hvt_chk #(
   parameter int W = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           en,
   input logic           ack,
   input logic           init_req,
   input logic           timeout,
   input hvt_pkg::phase_e phase,
   input logic [W-1:0]   cnt,
   input logic [W-1:0]   per_q
);
   import hvt_pkg::*;

   assert_idle_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT) |-> (init_req && cnt == W'(1)));

   assert_hold_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && phase == PH_WAIT && !ack) |=> (phase == PH_WAIT && !timeout));

   assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && phase == PH_RUN && cnt != per_q) |=> (cnt == W'($past(cnt) + W'(1))));

   assert_req_with_tmo_R5: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> init_req);

   assert_force_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (init_req && !timeout && phase == PH_WAIT));

   assert_refs_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (en && phase == PH_RUN && cnt != per_q) |=> $stable(per_q));
endmodule

bind hs_var_timer hvt_chk #(.W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (en),
   .ack      (ack),
   .init_req (init_req),
   .timeout  (timeout),
   .phase    (phase_q),
   .cnt      (cnt_q),
   .per_q    (per_q)
);

// File: tb/hs_var_timer_tb.sv
module hs_var_timer_tb;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         en = 1'b0;
   logic         ack = 1'b0;
   logic [W-1:0] high_ref = '0;
   logic [W-1:0] period_ref = W'(1);
   logic         init_req, timeout;

   int nchk = 0, nerr = 0;
   bit done = 0;

   always #2 clk = ~clk;

   hs_var_timer #(.CNT_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .high_ref(high_ref),
      .period_ref(period_ref), .ack(ack), .init_req(init_req), .timeout(timeout)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // behavioural reference: integers only
   int  m_cnt = 1, m_hi = 0, m_per = 1;
   bit  m_run = 0, m_init = 1, m_tmo = 0;

   always @(posedge clk) begin
      if (!rst_n || !en) begin
         m_run = 0; m_cnt = 1; m_init = 1; m_tmo = 0;
      end else begin
         m_tmo = 0;
         if (!m_run) begin
            if (ack) begin m_run = 1; m_hi = high_ref; m_per = period_ref; end
         end else if (m_cnt == m_per) begin
            m_tmo = 1; m_init = 1; m_cnt = 1;
            if (ack) begin m_hi = high_ref; m_per = period_ref; end
            else m_run = 0;
         end else begin
            if (m_cnt == m_hi) m_init = 0;
            m_cnt = m_cnt + 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(init_req == m_init, "R3 model init_req", init_req, m_init);
         chk(timeout == m_tmo, "R4 model timeout", timeout, m_tmo);
      end
   end

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   int t_low, t_tmo, n_low, n_tmo;
   int tq[$];

   task automatic clr_obs;
      t_low = -1; t_tmo = -1; n_low = 0; n_tmo = 0;
      tq.delete();
   endtask

   task automatic obs(input int i);
      if (!init_req) begin n_low++; if (t_low < 0) t_low = i; end
      if (timeout) begin n_tmo++; if (t_tmo < 0) t_tmo = i; tq.push_back(i); end
   endtask

   task automatic idle;
      ack = 0; en = 0; tick(); en = 1;
   endtask

   // single ack pulse on tick 1, then watch n ticks
   task automatic pulse_watch(input int hi, input int per, input int n);
      high_ref = W'(hi); period_ref = W'(per);
      clr_obs();
      ack = 1;
      for (int i = 1; i <= n; i++) begin
         tick();
         if (i == 1) ack = 0;
         obs(i);
      end
   endtask

   task automatic held_watch(input int hi, input int per, input int n);
      high_ref = W'(hi); period_ref = W'(per);
      clr_obs();
      ack = 1;
      for (int i = 1; i <= n; i++) begin
         tick();
         obs(i);
      end
      ack = 0;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      nchk++; nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) tick();
      chk(init_req == 1'b1, "R1 reset init_req", init_req, 1);
      chk(timeout == 1'b0, "R1 reset timeout", timeout, 0);
      rst_n = 1; en = 1;

      // R2: no acknowledge, wait forever
      clr_obs();
      for (int i = 1; i <= 25; i++) begin tick(); obs(i); end
      chk(n_tmo == 0, "R2 no timeout while waiting", n_tmo, 0);
      chk(n_low == 0, "R1 request held while waiting", n_low, 0);

      // R3 R4 R5: high 2, period 8
      pulse_watch(2, 8, 16);
      chk(t_low == 3, "R3 request drop tick", t_low, 3);
      chk(n_low == 6, "R3 low duration", n_low, 6);
      chk(t_tmo == 9, "R4 timeout tick", t_tmo, 9);
      chk(n_tmo == 1, "R5 single pulse then wait", n_tmo, 1);

      // R6: back-to-back periods with ack held
      idle();
      held_watch(3, 8, 36);
      chk(tq.size() == 4, "R6 timeouts in window", tq.size(), 4);
      if (tq.size() >= 3) begin
         chk(tq[1] - tq[0] == 8, "R6 spacing first", tq[1] - tq[0], 8);
         chk(tq[2] - tq[1] == 8, "R6 spacing second", tq[2] - tq[1], 8);
      end
      idle();

      // R7: high not below period, and high zero
      held_watch(8, 8, 30);
      chk(n_low == 0, "R7 equal refs no drop", n_low, 0);
      chk(n_tmo == 3, "R7 equal refs timeouts", n_tmo, 3);
      idle();
      held_watch(9, 5, 30);
      chk(n_low == 0, "R7 high above period no drop", n_low, 0);
      chk(n_tmo == 5, "R7 high above period timeouts", n_tmo, 5);
      idle();
      held_watch(0, 4, 20);
      chk(n_low == 0, "R7 high zero no drop", n_low, 0);
      idle();

      // R8: ack pulse during counting ignored
      high_ref = W'(2); period_ref = W'(10);
      clr_obs();
      ack = 1;
      for (int i = 1; i <= 22; i++) begin
         tick();
         ack = (i == 4);
         obs(i);
      end
      chk(t_tmo == 11, "R8 period unchanged by mid ack", t_tmo, 11);
      chk(n_tmo == 1, "R8 no restart from mid ack", n_tmo, 1);

      // R9: enable cleared mid-count
      high_ref = W'(2); period_ref = W'(8);
      ack = 1; tick(); ack = 0;
      repeat (3) tick();
      chk(init_req == 1'b0, "R9 precondition low", init_req, 0);
      en = 0; tick();
      chk(init_req == 1'b1, "R9 request forced high", init_req, 1);
      chk(timeout == 1'b0, "R9 timeout forced low", timeout, 0);
      en = 1;
      clr_obs();
      for (int i = 1; i <= 15; i++) begin tick(); obs(i); end
      chk(n_tmo == 0, "R9 waiting after enable", n_tmo, 0);

      // R10: reference update mid-period
      high_ref = W'(2); period_ref = W'(8);
      clr_obs();
      ack = 1;
      for (int i = 1; i <= 14; i++) begin
         tick();
         if (i == 1) ack = 0;
         if (i == 3) begin high_ref = W'(1); period_ref = W'(4); end
         obs(i);
      end
      chk(t_low == 3, "R10 old high used", t_low, 3);
      chk(t_tmo == 9, "R10 old period used", t_tmo, 9);
      pulse_watch(1, 4, 8);
      chk(t_low == 2, "R10 new high next period", t_low, 2);
      chk(t_tmo == 5, "R10 new period next period", t_tmo, 5);

      finish_run();
   end
endmodule